// File: doc/BRIEF.md
# NAND Sector Hamming ECC Accumulator

This block builds a Hamming-style parity code over NAND page data while the data bytes stream through the controller. The page is cut into 512-byte sectors. Each byte that arrives during the data phase is folded into a running pair of 12-bit parity fields. When the last byte of a sector is folded in, the finished code is stored in that sector's own result register. Folding then restarts from zero for the next sector.

Firmware or a page engine raises the enable only after the address cycles, so address bytes never enter the code. A clear pulse restarts the sector count. The page-size setting limits how many result registers one page may fill. A packing port selects one result register and rearranges its 24 code bits into the three bytes that are stored in the spare area. Error correction, bus timing and command sequencing are handled elsewhere.

Top module: `nand_ecc_accum`

## Requirements
- R1: Each data bit of a sector has a 12-bit address {byte index within sector[8:0], bit index within byte[2:0]}. For each address bit k (0..11), result bit k is the XOR of every data bit whose address bit k is 0, and result bit 16+k is the XOR of every data bit whose address bit k is 1.
- R2: Bits [15:12] and [31:28] of every result register always read as zero.
- R3: The code of sector n (counting from 0) is written into result register n on the clock edge that samples the 512th accepted byte of that sector. The running parity then restarts at zero for sector n+1.
- R4: page_sel allows 1 << page_sel sectors per page (0: 1, 1: 2, 2: 4, 3: 8). Once that many sectors are complete, further strobes change nothing until a clear.
- R5: A strobe with ecc_en low is neither folded into the parity nor counted as a byte.
- R6: A clear zeroes the running parity, the byte count and the sector index, and leaves every result register unchanged. If a clear is issued before each sector, every code lands in result register 0.
- R7: A strobe with ecc_en high in the same cycle as a clear is taken as byte 0 of sector 0 of a new page.
- R8: spare_bytes shows the register chosen by pack_sel (call it W) in packed form: spare_bytes[7:0] = W[7:0], spare_bytes[15:8] = W[23:16], spare_bytes[23:16] = {W[27:24], W[11:8]}.
- R9: A sector of all 0xFF bytes, or of all 0x00 bytes, gives the code 0. A sector that is all zero except for one set bit at address a gives, for each k, bit k set when a[k] = 0 and bit 16+k set when a[k] = 1.
- R10: Synchronous reset zeroes all result registers, the running parity and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Parity folding enable for the data phase |
| clear | input | 1 | Restart pulse for parity, byte count and sector index |
| data_vld | input | 1 | Strobe marking a data byte on data_in |
| data_in | input | 8 | Data byte |
| page_sel | input | PAGE_SEL_W (2) | Sectors per page, 1 << page_sel |
| pack_sel | input | SEL_W (3) | Result register shown on spare_bytes |
| result_flat | output | MAX_SECTORS*32 (256) | Result registers, sector n at [32n+31:32n] |
| spare_bytes | output | 24 | Packed spare-area bytes of the selected register |

## Verification
The assertions check on every cycle the properties that depend only on control: the reserved nibbles stay zero, no result register moves except when a sector completes, nothing moves after the page limit or while the enable is low, and both kinds of clear land on the right counter state. Only the bench scenarios can show whether the stored code values are correct. This covers the parity of random sectors against an independent bit-by-bit model, the known all-0xFF and single-bit codes, sector ordering across 2-, 4- and 8-sector pages, and the spare-area byte layout for each register.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int SECTOR_BYTES = 512;
    localparam int BYTE_W       = 8;
    localparam int BIT_IDX_W    = $clog2(BYTE_W);
    localparam int CNT_W        = $clog2(SECTOR_BYTES);
    localparam int CODE_W       = CNT_W + BIT_IDX_W;
    localparam int WORD_W       = 32;
    localparam int ODD_LSB      = 16;
    localparam int SPARE_W      = 24;

    // Even field covers address bit == 0, odd field covers address bit == 1
    typedef struct packed {
        logic [CODE_W-1:0] odd;
        logic [CODE_W-1:0] even;
    } ecc_par_t;

    function automatic ecc_par_t par_xor(ecc_par_t a, ecc_par_t b);
        ecc_par_t r;
        r.odd  = a.odd ^ b.odd;
        r.even = a.even ^ b.even;
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] par_to_word(ecc_par_t p);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CODE_W-1:0]         = p.even;
        w[ODD_LSB +: CODE_W]  = p.odd;
        return w;
    endfunction

    // Spare byte 2 interleaves the top nibbles of both fields
    function automatic logic [SPARE_W-1:0] word_to_spare(logic [WORD_W-1:0] w);
        return {w[27:24], w[11:8], w[23:16], w[7:0]};
    endfunction

endpackage

// File: rtl/ecc_byte_fold.sv
module ecc_byte_fold
    import nand_ecc_pkg::*;
(
    input  logic [BYTE_W-1:0] data,
    input  logic [CNT_W-1:0]  byte_idx,
    output ecc_par_t          contrib
);

    logic [CODE_W-1:0] ev;
    logic [CODE_W-1:0] od;
    logic              byte_par;

    assign byte_par = ^data;

    // Bit-position address bits: split the byte by bit index
    for (genvar k = 0; k < BIT_IDX_W; k++) begin : g_pos
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            if (((i >> k) & 1) == 1) begin : g_hi
                assign hi[i] = data[i];
                assign lo[i] = 1'b0;
            end else begin : g_lo
                assign hi[i] = 1'b0;
                assign lo[i] = data[i];
            end
        end
        assign od[k] = ^hi;
        assign ev[k] = ^lo;
    end

    // Byte-index address bits: whole-byte parity goes to one side
    for (genvar j = 0; j < CNT_W; j++) begin : g_addr
        assign od[BIT_IDX_W + j] = byte_par &  byte_idx[j];
        assign ev[BIT_IDX_W + j] = byte_par & ~byte_idx[j];
    end

    assign contrib.odd  = od;
    assign contrib.even = ev;

endmodule

// File: rtl/ecc_sector_seq.sv
module ecc_sector_seq
    import nand_ecc_pkg::*;
#(
    parameter int MAX_SECTORS = 8,
    parameter int PAGE_SEL_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ecc_en,
    input  logic                              clear,
    input  logic                              data_vld,
    input  logic [PAGE_SEL_W-1:0]             page_sel,
    output logic                              accept,
    output logic                              sec_done,
    output logic [CNT_W-1:0]                  byte_idx,
    output logic [$clog2(MAX_SECTORS+1)-1:0]  wr_idx,
    output logic [$clog2(MAX_SECTORS+1)-1:0]  cur_sec,
    output logic [CNT_W-1:0]                  cur_cnt,
    output logic [$clog2(MAX_SECTORS+1)-1:0]  nsec
);

    localparam int SEC_W = $clog2(MAX_SECTORS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SEC_W-1:0] sec_q;
    logic [31:0]      want;
    logic             room;

    always_comb begin
        want = 32'd1 << page_sel;
        nsec = (want > 32'(MAX_SECTORS)) ? SEC_W'(MAX_SECTORS) : SEC_W'(want);
    end

    assign room     = clear || (sec_q < nsec);
    assign accept   = data_vld && ecc_en && room;
    assign byte_idx = clear ? '0 : cnt_q;
    assign wr_idx   = clear ? '0 : sec_q;
    assign sec_done = accept && (byte_idx == CNT_W'(SECTOR_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sec_q <= '0;
        end else if (accept) begin
            if (sec_done) begin
                cnt_q <= '0;
                sec_q <= wr_idx + 1'b1;
            end else begin
                cnt_q <= byte_idx + 1'b1;
                sec_q <= wr_idx;
            end
        end else if (clear) begin
            cnt_q <= '0;
            sec_q <= '0;
        end
    end

    assign cur_sec = sec_q;
    assign cur_cnt = cnt_q;

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import nand_ecc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     accept,
    input  logic     sec_done,
    input  ecc_par_t contrib,
    output ecc_par_t code_next
);

    ecc_par_t acc_q;
    ecc_par_t base;

    assign base      = clear ? '0 : acc_q;
    assign code_next = par_xor(base, contrib);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q <= sec_done ? '0 : code_next;
        end else if (clear) begin
            acc_q <= '0;
        end
    end

endmodule

// File: rtl/ecc_result_bank.sv
module ecc_result_bank
    import nand_ecc_pkg::*;
#(
    parameter int MAX_SECTORS = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [$clog2(MAX_SECTORS+1)-1:0]  wr_idx,
    input  ecc_par_t                          wr_code,
    output logic [MAX_SECTORS*WORD_W-1:0]     res_flat
);

    localparam int SEC_W = $clog2(MAX_SECTORS + 1);

    for (genvar s = 0; s < MAX_SECTORS; s++) begin : g_reg
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == SEC_W'(s))) begin
                word_q <= par_to_word(wr_code);
            end
        end
        assign res_flat[s*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/ecc_spare_pack.sv
module ecc_spare_pack
    import nand_ecc_pkg::*;
#(
    parameter int MAX_SECTORS = 8,
    parameter int SEL_W       = 3
) (
    input  logic [SEL_W-1:0]              pack_sel,
    input  logic [MAX_SECTORS*WORD_W-1:0] res_flat,
    output logic [SPARE_W-1:0]            spare
);

    logic [WORD_W-1:0] chosen;

    always_comb begin
        chosen = '0;
        for (int s = 0; s < MAX_SECTORS; s++) begin
            if (pack_sel == SEL_W'(s)) begin
                chosen = res_flat[s*WORD_W +: WORD_W];
            end
        end
    end

    assign spare = word_to_spare(chosen);

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int MAX_SECTORS = 8,
    parameter int PAGE_SEL_W  = 2,
    parameter int SEL_W       = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ecc_en,
    input  logic                          clear,
    input  logic                          data_vld,
    input  logic [BYTE_W-1:0]             data_in,
    input  logic [PAGE_SEL_W-1:0]         page_sel,
    input  logic [SEL_W-1:0]              pack_sel,
    output logic [MAX_SECTORS*WORD_W-1:0] result_flat,
    output logic [SPARE_W-1:0]            spare_bytes
);

    localparam int SEC_W = $clog2(MAX_SECTORS + 1);

    logic             accept;
    logic             sec_done;
    logic [CNT_W-1:0] byte_idx;
    logic [SEC_W-1:0] wr_idx;
    logic [SEC_W-1:0] cur_sec;
    logic [CNT_W-1:0] cur_cnt;
    logic [SEC_W-1:0] nsec;
    ecc_par_t         contrib;
    ecc_par_t         code_next;

    ecc_sector_seq #(
        .MAX_SECTORS (MAX_SECTORS),
        .PAGE_SEL_W  (PAGE_SEL_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ecc_en   (ecc_en),
        .clear    (clear),
        .data_vld (data_vld),
        .page_sel (page_sel),
        .accept   (accept),
        .sec_done (sec_done),
        .byte_idx (byte_idx),
        .wr_idx   (wr_idx),
        .cur_sec  (cur_sec),
        .cur_cnt  (cur_cnt),
        .nsec     (nsec)
    );

    ecc_byte_fold u_fold (
        .data     (data_in),
        .byte_idx (byte_idx),
        .contrib  (contrib)
    );

    ecc_parity_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .accept    (accept),
        .sec_done  (sec_done),
        .contrib   (contrib),
        .code_next (code_next)
    );

    ecc_result_bank #(
        .MAX_SECTORS (MAX_SECTORS)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sec_done),
        .wr_idx   (wr_idx),
        .wr_code  (code_next),
        .res_flat (result_flat)
    );

    ecc_spare_pack #(
        .MAX_SECTORS (MAX_SECTORS),
        .SEL_W       (SEL_W)
    ) u_pack (
        .pack_sel (pack_sel),
        .res_flat (result_flat),
        .spare    (spare_bytes)
    );

endmodule

// File: rtl/ecc_accum_chk.sv
module ecc_accum_chk #(
    parameter int MAX_SECTORS = 8,
    parameter int SEC_W       = 4,
    parameter int CNT_W       = 9
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      clear,
    input logic                      ecc_en,
    input logic                      data_vld,
    input logic                      sec_done,
    input logic [SEC_W-1:0]          cur_sec,
    input logic [CNT_W-1:0]          cur_cnt,
    input logic [SEC_W-1:0]          nsec,
    input logic [MAX_SECTORS*32-1:0] result_flat
);

    localparam logic [MAX_SECTORS*32-1:0] RSV_MASK = {MAX_SECTORS{32'hF000_F000}};

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (result_flat & RSV_MASK) == '0);

    // R3
    bank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_done |=> $stable(result_flat));

    // R3
    sector_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cur_sec <= SEC_W'(MAX_SECTORS));

    // R4
    page_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_sec >= nsec && !clear) |=> ($stable(result_flat) && $stable(cur_cnt)));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ecc_en && !clear) |=> ($stable(cur_cnt) && $stable(cur_sec) && $stable(result_flat)));

    // R6
    clear_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !(data_vld && ecc_en)) |=> (cur_sec == '0 && cur_cnt == '0));

    // R7
    clear_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && data_vld && ecc_en) |=> (cur_sec == '0 && cur_cnt == CNT_W'(1)));

endmodule

bind nand_ecc_accum ecc_accum_chk #(
    .MAX_SECTORS (MAX_SECTORS),
    .SEC_W       (SEC_W),
    .CNT_W       (nand_ecc_pkg::CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear       (clear),
    .ecc_en      (ecc_en),
    .data_vld    (data_vld),
    .sec_done    (sec_done),
    .cur_sec     (cur_sec),
    .cur_cnt     (cur_cnt),
    .nsec        (nsec),
    .result_flat (result_flat)
);

// File: tb/test_nand_ecc_accum.sv
module test_nand_ecc_accum;

    localparam int MAXS = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              ecc_en;
    logic              clear;
    logic              data_vld;
    logic [7:0]        data_in;
    logic [1:0]        page_sel;
    logic [2:0]        pack_sel;
    logic [MAXS*32-1:0] result_flat;
    logic [23:0]       spare_bytes;

    int          n_chk = 0;
    int          n_err = 0;
    logic [11:0] m_even;
    logic [11:0] m_odd;
    int          m_cnt;
    int          m_sec;
    logic [31:0] m_res [MAXS];

    always #4 clk = ~clk;

    nand_ecc_accum i_nand_ecc_accum (
        .clk         (clk),
        .rst         (rst),
        .ecc_en      (ecc_en),
        .clear       (clear),
        .data_vld    (data_vld),
        .data_in     (data_in),
        .page_sel    (page_sel),
        .pack_sel    (pack_sel),
        .result_flat (result_flat),
        .spare_bytes (spare_bytes)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One input cycle, then the bench's own bit-level model of the rules
    task automatic step(bit vld, bit en, bit clr, logic [7:0] d);
        bit          take;
        logic [11:0] addr;
        @(negedge clk);
        data_vld = vld;
        ecc_en   = en;
        clear    = clr;
        data_in  = d;
        @(posedge clk);
        take = vld && en && (clr || m_sec < (1 << page_sel));
        if (clr) begin
            m_even = '0; m_odd = '0; m_cnt = 0; m_sec = 0;
        end
        if (take) begin
            for (int i = 0; i < 8; i++) begin
                if (d[i]) begin
                    addr = {m_cnt[8:0], 3'(i)};
                    for (int k = 0; k < 12; k++) begin
                        if (addr[k]) m_odd[k] = ~m_odd[k];
                        else         m_even[k] = ~m_even[k];
                    end
                end
            end
            m_cnt++;
            if (m_cnt == 512) begin
                m_res[m_sec] = {4'h0, m_odd, 4'h0, m_even};
                m_even = '0; m_odd = '0; m_cnt = 0; m_sec++;
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        data_vld = 1'b0;
        clear    = 1'b0;
        ecc_en   = 1'b0;
    endtask

    task automatic check_all(string req);
        logic [31:0] w;
        for (int s = 0; s < MAXS; s++) begin
            w = result_flat[s*32 +: 32];
            check(req, $sformatf("result[%0d]", s), w, m_res[s]);
            check("R2", $sformatf("reserved[%0d]", s), w & 32'hF000F000, 32'h0);
            pack_sel = 3'(s);
            #1;
            check("R8", $sformatf("spare[%0d]", s), {8'h0, spare_bytes},
                  {8'h0, m_res[s][27:24], m_res[s][11:8], m_res[s][23:16], m_res[s][7:0]});
        end
    endtask

    task automatic rand_bytes(int n, int gap_pct);
        for (int i = 0; i < n; i++) begin
            step(1'b1, ($urandom % 100) >= gap_pct, 1'b0, 8'($urandom));
        end
    endtask

    function automatic logic [31:0] one_bit_code(int byte_i, int bit_i);
        logic [11:0] a;
        logic [31:0] w;
        a = {9'(byte_i), 3'(bit_i)};
        w = '0;
        for (int k = 0; k < 12; k++) begin
            if (a[k]) w[16 + k] = 1'b1;
            else      w[k] = 1'b1;
        end
        return w;
    endfunction

    task automatic single_bit_sector(int byte_i, int bit_i);
        step(1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 512; i++) begin
            step(1'b1, 1'b1, 1'b0, (i == byte_i) ? 8'(1 << bit_i) : 8'h00);
        end
        idle();
        check("R9", $sformatf("single bit %0d.%0d", byte_i, bit_i),
              result_flat[31:0], one_bit_code(byte_i, bit_i));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R3 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] snap [MAXS];
        void'($urandom(32'd2024));
        rst = 1'b1; ecc_en = 1'b0; clear = 1'b0; data_vld = 1'b0;
        data_in = '0; page_sel = 2'd0; pack_sel = '0;
        m_even = '0; m_odd = '0; m_cnt = 0; m_sec = 0;
        for (int s = 0; s < MAXS; s++) m_res[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check_all("R10");

        // R5: disabled strobes inside a sector neither fold nor count
        page_sel = 2'd0;
        rand_bytes(300, 0);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 8'hA5);
        rand_bytes(212, 0);
        idle();
        check_all("R5");

        // R1 R3: 4-sector page with random enable gaps
        page_sel = 2'd2;
        step(1'b0, 1'b0, 1'b1, 8'h00);
        while (m_sec < 4) rand_bytes(1, 10);
        idle();
        check_all("R1");
        check("R3", "sector index", 32'(m_sec), 32'd4);

        // R4: strobes past the page limit are ignored
        for (int s = 0; s < MAXS; s++) snap[s] = result_flat[s*32 +: 32];
        rand_bytes(80, 0);
        idle();
        for (int s = 0; s < MAXS; s++)
            check("R4", $sformatf("held[%0d]", s), result_flat[s*32 +: 32], snap[s]);

        // R9: all-0xFF sector gives zero; R6: other registers keep values
        page_sel = 2'd0;
        step(1'b0, 1'b0, 1'b1, 8'h00);
        for (int i = 0; i < 512; i++) step(1'b1, 1'b1, 1'b0, 8'hFF);
        idle();
        check("R9", "all 0xFF", result_flat[31:0], 32'h0);
        for (int s = 1; s < 4; s++)
            check("R6", $sformatf("kept[%0d]", s), result_flat[s*32 +: 32], snap[s]);

        // R9: single bit flips at corners and middle
        single_bit_sector(0, 0);
        single_bit_sector(511, 7);
        single_bit_sector(300, 5);

        // R7: strobe together with clear is byte 0 of sector 0
        page_sel = 2'd1;
        step(1'b1, 1'b1, 1'b1, 8'h3C);
        rand_bytes(511, 0);
        idle();
        check_all("R7");

        // R6: clear before each sector keeps every code in register 0
        page_sel = 2'd3;
        for (int s = 0; s < MAXS; s++) snap[s] = result_flat[s*32 +: 32];
        for (int r = 0; r < 3; r++) begin
            step(1'b0, 1'b0, 1'b1, 8'h00);
            rand_bytes(512, 0);
            idle();
            for (int s = 1; s < MAXS; s++)
                check("R6", $sformatf("untouched[%0d]", s), result_flat[s*32 +: 32], snap[s]);
            check("R6", "reg0", result_flat[31:0], m_res[0]);
        end

        // R3: full 8-sector page
        step(1'b0, 1'b0, 1'b1, 8'h00);
        rand_bytes(4096, 0);
        idle();
        check_all("R3");
        check("R3", "sector index", 32'(m_sec), 32'd8);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule